// File: doc/BRIEF.md
# Indirect Interrupt Routing Register Window

This block is the register file of an interrupt routing controller with 24 inputs. Software reaches it through two 32-bit bus locations. The first is a select register that holds an 8-bit index. The second is a data window, and an access to it lands on whichever register the select value names. Behind the window are an identification byte, a fixed version word, an arbitration word that always reads as zero, and a table of 64-bit routing entries. Each routing entry is reached as two 32-bit halves at consecutive select values.

The whole table is driven out as one flat bus to the dispatch logic on every cycle. After every write that lands on a table entry, the block raises a one-cycle update strobe together with the entry index, so dispatch can re-evaluate pending requests. The bus side is a plain strobe interface with no back-pressure. Any read strobe is answered exactly one cycle later with a valid pulse and the data word. Writes take effect on the clock edge that samples them.

Top module: `irq_route_regfile`

## Requirements
- R1: Only address bits 7:0 are decoded. The low byte 0x00 selects the select register and 0x10 selects the data window. Any other low byte reads as zero and ignores writes, whatever the upper address bits are.
- R2: A write to the select register stores wdata bits 7:0. A read returns that byte zero-extended to 32 bits.
- R3: The window at select 0x01 reads 0x00170011: version 0x11 in bits 7:0 and the highest entry index (23) in bits 23:16. Writes to it change nothing.
- R4: The window at select 0x00 reads the 8-bit ID in bits 31:24, with all other bits zero. A write there stores only wdata bits 31:24.
- R5: Select 0x02 and selects 0x03 to 0x0F read as zero through the window and ignore writes.
- R6: For a select value S of 0x10 or more, the entry index is (S-0x10)>>1. An even S reaches entry bits 31:0 and an odd S reaches entry bits 63:32, for both reads and writes.
- R7: A window write to one half of an entry leaves the other half of that entry unchanged.
- R8: A select value whose entry index is 24 or more reads as zero through the window. A write there changes no entry and raises no update strobe.
- R9: After reset every entry is 0x0000_0000_0001_0000 (only the mask bit 16 set), the ID is zero, the select register is zero, and no strobe or read valid is asserted.
- R10: A read strobe gives bus_rvalid high in the next cycle only. bus_rdata then holds the value as it stood before the edge that sampled the strobe.
- R11: A window write to a valid entry raises tbl_upd for exactly the next cycle, with tbl_upd_idx equal to the entry index. With no such write, tbl_upd is low.
- R12: route_table bits [64*i+63:64*i] hold entry i. They change only in the cycle after a window write to that entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 12 | Byte address; only bits 7:0 are decoded |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read answer, one cycle after bus_rd |
| route_table | output | 1536 | All routing entries, entry i at bits 64*i+63:64*i |
| tbl_upd | output | 1 | One-cycle pulse after an entry write |
| tbl_upd_idx | output | 5 | Index of the entry written, valid with tbl_upd |

## Verification
The checker assumes that bus_rd and bus_wr are never high in the same cycle. It also assumes each strobe is one access: no other agent moves the select register between the select write and the window access of a pair. The bench keeps to these assumptions by issuing every access through one task that raises a single strobe for one cycle and then drops it. Because the select value is always written just before the window access that depends on it, every check ties a window access to a known target.

// File: rtl/irt_pkg.sv
package irt_pkg;

  typedef enum logic [2:0] {
    TGT_NONE,
    TGT_SEL,
    TGT_ID,
    TGT_VER,
    TGT_ARB,
    TGT_ENT
  } tgt_e;

  localparam logic [7:0]  OFS_SEL       = 8'h00;
  localparam logic [7:0]  OFS_WIN       = 8'h10;
  localparam logic [7:0]  SEL_ID        = 8'h00;
  localparam logic [7:0]  SEL_VER       = 8'h01;
  localparam logic [7:0]  SEL_ARB       = 8'h02;
  localparam logic [7:0]  SEL_TBL_BASE  = 8'h10;
  localparam logic [7:0]  VERSION_CODE  = 8'h11;
  localparam int          MASK_BIT      = 16;
  localparam logic [63:0] ENTRY_RST     = 64'h1 << MASK_BIT;

endpackage

// File: rtl/irt_decode.sv
module irt_decode
  import irt_pkg::*;
#(
  parameter int NUM_ENT = 24,
  parameter int ADDR_W  = 12,
  parameter int IDX_W   = 5
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        sel,
  output tgt_e              tgt,
  output logic [IDX_W-1:0]  ent_idx,
  output logic              ent_hi
);

  logic [7:0] rel;
  logic [6:0] slot;
  logic       unused_addr_hi;

  // upper address bits are deliberately not decoded
  assign unused_addr_hi = ^addr[ADDR_W-1:8];

  always_comb begin
    rel     = sel - SEL_TBL_BASE;
    slot    = rel[7:1];
    ent_idx = IDX_W'(slot);
    ent_hi  = rel[0];
    tgt     = TGT_NONE;
    if (addr[7:0] == OFS_SEL) begin
      tgt = TGT_SEL;
    end else if (addr[7:0] == OFS_WIN) begin
      case (sel)
        SEL_ID:  tgt = TGT_ID;
        SEL_VER: tgt = TGT_VER;
        SEL_ARB: tgt = TGT_ARB;
        default: begin
          if (sel >= SEL_TBL_BASE && 32'(slot) < NUM_ENT) tgt = TGT_ENT;
        end
      endcase
    end
  end

endmodule

// File: rtl/irt_entry_bank.sv
module irt_entry_bank
  import irt_pkg::*;
#(
  parameter int NUM_ENT = 24,
  parameter int IDX_W   = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we,
  input  logic [IDX_W-1:0]       widx,
  input  logic                   whi,
  input  logic [31:0]            wdata,
  input  logic [IDX_W-1:0]       ridx,
  input  logic                   rhi,
  output logic [31:0]            rword,
  output logic [NUM_ENT*64-1:0]  table_flat,
  output logic                   upd,
  output logic [IDX_W-1:0]       upd_idx
);

  localparam int SLOTS = 1 << IDX_W;

  logic [63:0] ent_arr [SLOTS];

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    if (g < NUM_ENT) begin : g_live
      logic [63:0] ent_q;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          ent_q <= ENTRY_RST;
        end else if (we && widx == IDX_W'(g)) begin
          if (whi) ent_q[63:32] <= wdata;
          else     ent_q[31:0]  <= wdata;
        end
      end
      assign ent_arr[g]             = ent_q;
      assign table_flat[g*64 +: 64] = ent_q;
    end else begin : g_pad
      assign ent_arr[g] = '0;
    end
  end

  assign rword = rhi ? ent_arr[ridx][63:32] : ent_arr[ridx][31:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      upd     <= 1'b0;
      upd_idx <= '0;
    end else begin
      upd <= we;
      if (we) upd_idx <= widx;
    end
  end

endmodule

// File: rtl/irt_read_mux.sv
module irt_read_mux
  import irt_pkg::*;
#(
  parameter int NUM_ENT = 24
) (
  input  tgt_e        tgt,
  input  logic [7:0]  sel,
  input  logic [7:0]  id,
  input  logic [31:0] ent_word,
  output logic [31:0] word
);

  localparam logic [7:0] TOP_IDX = 8'(NUM_ENT - 1);

  always_comb begin
    case (tgt)
      TGT_SEL: word = {24'h0, sel};
      TGT_ID:  word = {id, 24'h0};
      TGT_VER: word = {8'h00, TOP_IDX, 8'h00, VERSION_CODE};
      TGT_ENT: word = ent_word;
      default: word = 32'h0;
    endcase
  end

endmodule

// File: rtl/irq_route_regfile.sv
module irq_route_regfile
  import irt_pkg::*;
#(
  parameter int NUM_ENT = 24,
  parameter int ADDR_W  = 12,
  localparam int IDX_W  = $clog2(NUM_ENT)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic                  bus_wr,
  input  logic [31:0]           bus_wdata,
  input  logic                  bus_rd,
  output logic [31:0]           bus_rdata,
  output logic                  bus_rvalid,
  output logic [NUM_ENT*64-1:0] route_table,
  output logic                  tbl_upd,
  output logic [IDX_W-1:0]      tbl_upd_idx
);

  tgt_e             tgt;
  logic [IDX_W-1:0] ent_idx;
  logic             ent_hi;
  logic [7:0]       sel_q;
  logic [7:0]       id_q;
  logic [31:0]      ent_word;
  logic [31:0]      mux_word;
  logic             ent_we;

  irt_decode #(.NUM_ENT(NUM_ENT), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_dec (
    .addr    (bus_addr),
    .sel     (sel_q),
    .tgt     (tgt),
    .ent_idx (ent_idx),
    .ent_hi  (ent_hi)
  );

  assign ent_we = bus_wr && (tgt == TGT_ENT);

  irt_entry_bank #(.NUM_ENT(NUM_ENT), .IDX_W(IDX_W)) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .we         (ent_we),
    .widx       (ent_idx),
    .whi        (ent_hi),
    .wdata      (bus_wdata),
    .ridx       (ent_idx),
    .rhi        (ent_hi),
    .rword      (ent_word),
    .table_flat (route_table),
    .upd        (tbl_upd),
    .upd_idx    (tbl_upd_idx)
  );

  irt_read_mux #(.NUM_ENT(NUM_ENT)) u_mux (
    .tgt      (tgt),
    .sel      (sel_q),
    .id       (id_q),
    .ent_word (ent_word),
    .word     (mux_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q <= '0;
      id_q  <= '0;
    end else if (bus_wr) begin
      if (tgt == TGT_SEL) sel_q <= bus_wdata[7:0];
      if (tgt == TGT_ID)  id_q  <= bus_wdata[31:24];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) bus_rdata <= mux_word;
    end
  end

endmodule

// File: rtl/irt_checker.sv
module irt_checker #(
  parameter int NUM_ENT = 24,
  localparam int IDX_W  = $clog2(NUM_ENT)
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [7:0]            addr_lo,
  input logic                  bus_wr,
  input logic [7:0]            wdata_lo,
  input logic                  bus_rd,
  input logic [31:0]           bus_rdata,
  input logic                  bus_rvalid,
  input logic [NUM_ENT*64-1:0] route_table,
  input logic                  tbl_upd,
  input logic [IDX_W-1:0]      tbl_upd_idx,
  input logic [7:0]            sel_q
);

  localparam logic [31:0] VER_WORD = {8'h00, 8'(NUM_ENT - 1), 8'h00, 8'h11};

  assert_rvalid_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> bus_rvalid);

  assert_rvalid_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> !bus_rvalid);

  assert_table_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> $stable(route_table));

  assert_no_stray_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> !tbl_upd);

  assert_strobe_index_R11: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_upd |-> (32'(tbl_upd_idx) < NUM_ENT));

  assert_version_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && addr_lo == 8'h10 && sel_q == 8'h01) |=> (bus_rdata == VER_WORD));

  assert_select_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && addr_lo == 8'h00) |=> (sel_q == $past(wdata_lo)));

endmodule

bind irq_route_regfile irt_checker #(.NUM_ENT(NUM_ENT)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .addr_lo     (bus_addr[7:0]),
  .bus_wr      (bus_wr),
  .wdata_lo    (bus_wdata[7:0]),
  .bus_rd      (bus_rd),
  .bus_rdata   (bus_rdata),
  .bus_rvalid  (bus_rvalid),
  .route_table (route_table),
  .tbl_upd     (tbl_upd),
  .tbl_upd_idx (tbl_upd_idx),
  .sel_q       (sel_q)
);

// File: tb/irq_route_regfile_bench.sv
`timescale 1ns/1ps
module irq_route_regfile_bench;

  localparam int NE = 24;
  localparam logic [31:0] VER = 32'h0017_0011;
  localparam logic [63:0] RSTV = 64'h0000_0000_0001_0000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [11:0]   bus_addr = '0;
  logic          bus_wr = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic          bus_rd = 1'b0;
  logic [31:0]   bus_rdata;
  logic          bus_rvalid;
  logic [NE*64-1:0] route_table;
  logic          tbl_upd;
  logic [4:0]    tbl_upd_idx;

  int checks = 0;
  int failures = 0;
  logic [63:0] mdl [NE];
  logic [31:0] exp_q [$];
  string       tag_q [$];

  always #2 clk = ~clk;

  irq_route_regfile u_irq_route_regfile (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .route_table(route_table), .tbl_upd(tbl_upd),
    .tbl_upd_idx(tbl_upd_idx)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pops the scoreboard whenever a read answer appears
  always @(negedge clk) begin
    if (rst_n && bus_rvalid) begin
      if (exp_q.size() == 0) begin
        checks++; failures++;
        $display("FAIL R10 actual=unexpected rvalid expected=none");
      end else begin
        chk(tag_q.pop_front(), {32'h0, bus_rdata}, {32'h0, exp_q.pop_front()});
      end
    end
  end

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [11:0] a, input logic [31:0] e, input string req);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    exp_q.push_back(e); tag_q.push_back(req);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic check_table(input string req);
    for (int i = 0; i < NE; i++) chk(req, route_table[i*64 +: 64], mdl[i]);
  endtask

  // select s, then write d through the window; checks strobe and table
  task automatic win_write(input logic [7:0] s, input logic [31:0] d, input string req);
    int idx;
    bit hit;
    bus_write(12'h000, {24'h0, s});
    idx = (int'(s) - 16) >>> 1;
    hit = (s >= 8'h10) && (idx < NE);
    if (hit) begin
      if (s[0]) mdl[idx][63:32] = d;
      else      mdl[idx][31:0]  = d;
    end
    bus_write(12'h010, d);
    chk({req, " strobe"}, {63'h0, tbl_upd}, {63'h0, hit});
    if (hit) chk({req, " strobe idx"}, {59'h0, tbl_upd_idx}, 64'(idx));
    check_table(req);
  endtask

  task automatic win_read(input logic [7:0] s, input logic [31:0] e, input string req);
    bus_write(12'h000, {24'h0, s});
    bus_read(12'h010, e, req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < NE; i++) mdl[i] = RSTV;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    check_table("R9 reset table");
    chk("R9 no strobe", {63'h0, tbl_upd}, 64'h0);
    chk("R9 no rvalid", {63'h0, bus_rvalid}, 64'h0);
    bus_read(12'h000, 32'h0, "R9 select zero");
    bus_read(12'h010, 32'h0, "R9 id zero");
    bus_read(12'h010, 32'h0, "R10 back to back read");

    // R2 select register
    bus_write(12'h000, 32'hFFFF_FFA5);
    bus_read(12'h000, 32'h0000_00A5, "R2 select readback");

    // R4 identification byte
    bus_write(12'h000, 32'h0);
    bus_write(12'h010, 32'hDEAD_BEEF);
    bus_read(12'h010, 32'hDE00_0000, "R4 id byte only");

    // R3 version read-only
    win_read(8'h01, VER, "R3 version");
    win_write(8'h01, 32'hFFFF_FFFF, "R3 version write");
    win_read(8'h01, VER, "R3 version after write");

    // R5 arbitration and reserved selects
    win_read(8'h02, 32'h0, "R5 arb zero");
    win_write(8'h02, 32'h1234_5678, "R5 arb write");
    win_read(8'h02, 32'h0, "R5 arb after write");
    win_read(8'h05, 32'h0, "R5 reserved select");
    win_read(8'h00, 32'hDE00_0000, "R5 id untouched");

    // R6 R7 R12 entry halves
    win_write(8'h10, 32'hAAAA_5555, "R12 entry0 low");
    win_read(8'h10, 32'hAAAA_5555, "R6 entry0 low read");
    win_read(8'h11, 32'h0, "R7 entry0 high kept");
    win_write(8'h11, 32'h0102_0304, "R12 entry0 high");
    win_read(8'h10, 32'hAAAA_5555, "R7 entry0 low kept");
    win_read(8'h11, 32'h0102_0304, "R6 entry0 high read");
    win_write(8'h1B, 32'h5A5A_0F0F, "R6 entry5 high");
    win_read(8'h1A, RSTV[31:0], "R7 entry5 low kept");
    win_write(8'h3F, 32'hCAFE_F00D, "R6 entry23 high");
    win_write(8'h3E, 32'h0000_00C3, "R6 entry23 low");
    win_read(8'h3F, 32'hCAFE_F00D, "R6 entry23 high read");
    chk("R11 strobe one cycle", {63'h0, tbl_upd}, 64'h0);

    // R8 out-of-range indices
    win_write(8'h40, 32'hFFFF_FFFF, "R8 index24 low");
    win_write(8'h41, 32'hFFFF_FFFF, "R8 index24 high");
    win_write(8'hFF, 32'hFFFF_FFFF, "R8 select ff");
    win_read(8'h40, 32'h0, "R8 index24 read");
    win_read(8'hFF, 32'h0, "R8 select ff read");

    // R1 address decode
    bus_write(12'h000, 32'h3E);
    bus_write(12'h020, 32'h77);
    bus_write(12'h004, 32'h66);
    check_table("R1 stray writes");
    bus_read(12'h000, 32'h3E, "R1 select unchanged");
    bus_read(12'h020, 32'h0, "R1 offset 0x20 zero");
    bus_read(12'h004, 32'h0, "R1 offset 0x04 zero");
    bus_read(12'h110, 32'h0000_00C3, "R1 high address bits ignored");
    bus_write(12'h300, 32'h11);
    bus_read(12'h000, 32'h11, "R1 aliased select");

    repeat (3) @(negedge clk);
    chk("R10 scoreboard drained", 64'(exp_q.size()), 64'h0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule